// File: doc/BRIEF.md
# Transfer Count and Activation-Enable Unit

This block is the counting and completion part of a small interrupt-driven data transfer engine. It holds two 16-bit count registers (A and B), a configuration register and a bank of 56 activation-enable bits, one for each interrupt source. The transfer engine pulses a strobe after each data item it moves, together with the number of the source being served. On each strobe the unit updates its counters according to the selected mode and reports when a block or the whole job has finished. It also drops the enable bit of the served source when the clearing rules require it, which hands the interrupt on to the CPU.

In normal mode, register A is a single 16-bit down-counter. In repeat and block modes, A works as two bytes. The high byte keeps the programmed length. The low byte counts down and reloads itself from the high byte when it reaches zero. In block mode, register B counts finished blocks, and the job ends when B reaches zero. Software reaches all registers through a simple synchronous bus port.

Top module: `xfer_count_unit`

## Requirements
- R1: After reset, the configuration, both count registers and all 56 enable bits read as zero, and `xfer_end_o`, `blk_end_o` and `cpu_irq_o` are low.
- R2: Bus register map. Address 0 is configuration (bits 1:0 mode, bit 2 disable-interrupt flag). Address 1 is count A and address 2 is count B. Addresses 8 to 14 are enable registers 0 to 6, each in bits 7:0. Read data appears on `bus_rdata` one cycle after a read and is zero for any other address.
- R3: In mode code 0 or 3 (normal), each strobe decrements A by one. A strobe taken while A equals 1 gives a one-cycle `xfer_end_o` pulse. A programmed 0 wraps to 0xFFFF.
- R4: In mode code 1 (repeat) or 2 (block), a strobe leaves A[15:8] unchanged. It decrements A[7:0] when A[7:0] is not 1. When A[7:0] is 1, it loads A[15:8] into A[7:0] and pulses `blk_end_o`. A low byte of 0 counts 256 strobes.
- R5: In repeat mode, `xfer_end_o` never pulses.
- R6: In block mode, B decrements on each strobe that reloads the low byte of A. The reload that finds B equal to 1 pulses `xfer_end_o`. A programmed B of 0 wraps to 0xFFFF.
- R7: When the disable-interrupt flag is 1, every strobe clears the enable bit of the served source and pulses `cpu_irq_o`.
- R8: A strobe that ends the transfer clears the served source's enable bit and pulses `cpu_irq_o`. With the flag 0 and no end, the bit stays set. Other sources' bits are never changed by a strobe.
- R9: `act_en_o[8*k+j]` is bit j of enable register k. A strobe names source number 8*k+j on `xfer_src`. Enable bits become 1 only through bus writes.
- R10: `xfer_end_o`, `blk_end_o` and `cpu_irq_o` are registered single-cycle pulses that appear in the clock cycle after the strobe that causes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| xfer_strobe | input | 1 | One data item has been moved |
| xfer_src | input | 6 | Source number served by the strobe |
| xfer_end_o | output | 1 | Whole transfer finished |
| blk_end_o | output | 1 | Low byte of A reloaded |
| cpu_irq_o | output | 1 | Interrupt passed on to the CPU |
| act_en_o | output | 56 | Activation-enable bits |

## Verification
Each result is due one clock after the edge that samples its cause. The end, block and interrupt pulses follow one cycle after the strobe. A read returns its data one cycle after the access. The new counter and enable values show on `act_en_o` or can be read back from the cycle after the strobe. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. It then compares every output with that model on the next falling edge, so each expected value is checked in exactly the cycle it is due. Directed read-backs after each scenario confirm the counter values and the surviving enable bits.

// File: rtl/xcu_pkg.sv
package xcu_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL     = 2'd0,
    MODE_REPEAT     = 2'd1,
    MODE_BLOCK      = 2'd2,
    MODE_NORMAL_ALT = 2'd3
  } xfer_mode_e;

  localparam int ADR_CFG     = 0;
  localparam int ADR_CNTA    = 1;
  localparam int ADR_CNTB    = 2;
  localparam int ADR_EN_BASE = 8;
endpackage

// File: rtl/xcu_counter.sv
module xcu_counter
  import xcu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  xfer_mode_e       mode,
  input  logic             strobe,
  input  logic             wr_a,
  input  logic             wr_b,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_a,
  output logic [CNT_W-1:0] cnt_b,
  output logic             blk_now,
  output logic             end_now
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] a_q, b_q, a_nx, b_nx;
  logic [HALF-1:0]  a_lo, a_hi;
  logic             lo_wrap;

  assign a_lo    = a_q[HALF-1:0];
  assign a_hi    = a_q[CNT_W-1:HALF];
  assign lo_wrap = (a_lo == HALF'(1));

  always_comb begin
    a_nx    = a_q;
    b_nx    = b_q;
    blk_now = 1'b0;
    end_now = 1'b0;
    if (strobe) begin
      case (mode)
        MODE_REPEAT, MODE_BLOCK: begin
          blk_now = lo_wrap;
          a_nx    = {a_hi, (lo_wrap ? a_hi : a_lo - 1'b1)};
          if (mode == MODE_BLOCK && lo_wrap) begin
            b_nx    = b_q - 1'b1;
            end_now = (b_q == CNT_W'(1));
          end
        end
        default: begin
          a_nx    = a_q - 1'b1;
          end_now = (a_q == CNT_W'(1));
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= wr_a ? wdata : a_nx;
      b_q <= wr_b ? wdata : b_nx;
    end
  end

  assign cnt_a = a_q;
  assign cnt_b = b_q;
endmodule

// File: rtl/xcu_enable_bank.sv
module xcu_enable_bank #(
  parameter int EN_REGS = 7,
  parameter int EN_W    = 8,
  parameter int RIDX_W  = 3,
  parameter int BIT_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic [RIDX_W-1:0]       wr_idx,
  input  logic [EN_W-1:0]         wr_data,
  input  logic                    clr,
  input  logic [RIDX_W-1:0]       clr_reg,
  input  logic [BIT_W-1:0]        clr_bit,
  output logic [EN_REGS*EN_W-1:0] bits
);
  for (genvar k = 0; k < EN_REGS; k++) begin : g_reg
    logic [EN_W-1:0] r_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        r_q <= '0;
      end else if (wr && wr_idx == RIDX_W'(k)) begin
        r_q <= wr_data;
      end else if (clr && clr_reg == RIDX_W'(k)) begin
        r_q[clr_bit] <= 1'b0;
      end
    end
    assign bits[k*EN_W +: EN_W] = r_q;
  end
endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit
  import xcu_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 4,
  parameter int EN_REGS = 7,
  parameter int EN_W    = 8,
  parameter int NSRC    = EN_REGS * EN_W,
  parameter int RIDX_W  = (EN_REGS > 1) ? $clog2(EN_REGS) : 1,
  parameter int BIT_W   = $clog2(EN_W),
  parameter int SRC_W   = RIDX_W + BIT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              xfer_strobe,
  input  logic [SRC_W-1:0]  xfer_src,
  output logic              xfer_end_o,
  output logic              blk_end_o,
  output logic              cpu_irq_o,
  output logic [NSRC-1:0]   act_en_o
);
  xfer_mode_e       mode_q;
  logic             dis_q;
  logic [CNT_W-1:0] cnt_a, cnt_b, rd_mux;
  logic             blk_now, end_now;
  logic             wr_cfg, wr_a, wr_b, wr_en, en_hit;
  logic [RIDX_W-1:0] en_idx, src_reg;
  logic [BIT_W-1:0]  src_bit;
  logic              src_ok, clr_now;
  int                en_off;

  assign en_off = int'(bus_addr) - ADR_EN_BASE;
  assign en_hit = (en_off >= 0) && (en_off < EN_REGS);
  assign en_idx = RIDX_W'(en_off);

  assign wr_cfg = bus_sel && bus_we && (int'(bus_addr) == ADR_CFG);
  assign wr_a   = bus_sel && bus_we && (int'(bus_addr) == ADR_CNTA);
  assign wr_b   = bus_sel && bus_we && (int'(bus_addr) == ADR_CNTB);
  assign wr_en  = bus_sel && bus_we && en_hit;

  assign src_reg = xfer_src[SRC_W-1:BIT_W];
  assign src_bit = xfer_src[BIT_W-1:0];
  assign src_ok  = (int'(src_reg) < EN_REGS);
  assign clr_now = xfer_strobe && src_ok && (dis_q || end_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_NORMAL;
      dis_q  <= 1'b0;
    end else if (wr_cfg) begin
      mode_q <= xfer_mode_e'(bus_wdata[1:0]);
      dis_q  <= bus_wdata[2];
    end
  end

  xcu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_q),
    .strobe  (xfer_strobe),
    .wr_a    (wr_a),
    .wr_b    (wr_b),
    .wdata   (bus_wdata),
    .cnt_a   (cnt_a),
    .cnt_b   (cnt_b),
    .blk_now (blk_now),
    .end_now (end_now)
  );

  xcu_enable_bank #(
    .EN_REGS (EN_REGS),
    .EN_W    (EN_W),
    .RIDX_W  (RIDX_W),
    .BIT_W   (BIT_W)
  ) u_en (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr_en),
    .wr_idx  (en_idx),
    .wr_data (bus_wdata[EN_W-1:0]),
    .clr     (clr_now),
    .clr_reg (src_reg),
    .clr_bit (src_bit),
    .bits    (act_en_o)
  );

  always_comb begin
    rd_mux = '0;
    if (int'(bus_addr) == ADR_CFG)       rd_mux = CNT_W'({dis_q, mode_q});
    else if (int'(bus_addr) == ADR_CNTA) rd_mux = cnt_a;
    else if (int'(bus_addr) == ADR_CNTB) rd_mux = cnt_b;
    else if (en_hit)                     rd_mux = CNT_W'(act_en_o[en_idx*EN_W +: EN_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      xfer_end_o <= 1'b0;
      blk_end_o  <= 1'b0;
      cpu_irq_o  <= 1'b0;
    end else begin
      bus_rdata  <= (bus_sel && !bus_we) ? rd_mux : '0;
      xfer_end_o <= end_now;
      blk_end_o  <= blk_now;
      cpu_irq_o  <= clr_now;
    end
  end
endmodule

// File: rtl/xfer_count_chk.sv
module xfer_count_chk
  import xcu_pkg::*;
#(
  parameter int NSRC  = 56,
  parameter int SRC_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_sel,
  input logic             bus_we,
  input logic             xfer_strobe,
  input logic [SRC_W-1:0] xfer_src,
  input xfer_mode_e       mode,
  input logic             xfer_end_o,
  input logic             blk_end_o,
  input logic             cpu_irq_o,
  input logic [NSRC-1:0]  act_en_o
);
  p_end_after_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    xfer_end_o |-> $past(xfer_strobe));

  p_irq_after_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_irq_o |-> $past(xfer_strobe));

  p_end_gives_irq_r8: assert property (@(posedge clk) disable iff (rst)
    xfer_end_o |-> cpu_irq_o);

  p_repeat_no_end_r5: assert property (@(posedge clk) disable iff (rst)
    $past(xfer_strobe && mode == MODE_REPEAT) |-> !xfer_end_o);

  p_blk_needs_split_mode_r4: assert property (@(posedge clk) disable iff (rst)
    blk_end_o |-> $past(xfer_strobe && (mode == MODE_REPEAT || mode == MODE_BLOCK)));

  p_served_bit_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq_o && !$past(bus_sel && bus_we)) |-> !act_en_o[$past(xfer_src)]);

  p_set_only_by_write_r9: assert property (@(posedge clk) disable iff (rst)
    ((act_en_o & ~$past(act_en_o)) != '0) |-> $past(bus_sel && bus_we));
endmodule

bind xfer_count_unit xfer_count_chk #(.NSRC(NSRC), .SRC_W(SRC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_sel     (bus_sel),
  .bus_we      (bus_we),
  .xfer_strobe (xfer_strobe),
  .xfer_src    (xfer_src),
  .mode        (mode_q),
  .xfer_end_o  (xfer_end_o),
  .blk_end_o   (blk_end_o),
  .cpu_irq_o   (cpu_irq_o),
  .act_en_o    (act_en_o)
);

// File: tb/xfer_count_unit_test.sv
`timescale 1ns/1ps
module xfer_count_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        xfer_strobe = 1'b0;
  logic [5:0]  xfer_src = '0;
  logic        xfer_end_o, blk_end_o, cpu_irq_o;
  logic [55:0] act_en_o;

  int checks = 0, fails = 0;
  bit started = 0;

  always #5 clk = ~clk;

  xfer_count_unit uut (.*);

  // behavioural reference model
  int          m_mode, m_dis, m_a, m_b;
  logic [55:0] m_en;
  int          m_rdata;
  bit          m_end, m_blk, m_irq;

  always @(posedge clk) begin
    int lo, hi;
    started = 1;
    if (rst) begin
      m_mode = 0; m_dis = 0; m_a = 0; m_b = 0; m_en = '0;
      m_rdata = 0; m_end = 0; m_blk = 0; m_irq = 0;
    end else begin
      m_rdata = 0;
      if (bus_sel && !bus_we) begin
        if (bus_addr == 0)      m_rdata = m_dis * 4 + m_mode;
        else if (bus_addr == 1) m_rdata = m_a;
        else if (bus_addr == 2) m_rdata = m_b;
        else if (bus_addr >= 8 && bus_addr <= 14) m_rdata = int'(m_en[(bus_addr - 8) * 8 +: 8]);
      end
      m_end = 0; m_blk = 0; m_irq = 0;
      if (xfer_strobe) begin
        if (m_mode == 1 || m_mode == 2) begin
          lo = m_a % 256; hi = m_a / 256;
          if (lo == 1) begin
            lo = hi; m_blk = 1;
            if (m_mode == 2) begin
              if (m_b == 1) m_end = 1;
              m_b = (m_b + 65535) % 65536;
            end
          end else lo = (lo + 255) % 256;
          m_a = hi * 256 + lo;
        end else begin
          if (m_a == 1) m_end = 1;
          m_a = (m_a + 65535) % 65536;
        end
        if (m_dis == 1 || m_end) begin
          m_en[xfer_src] = 1'b0;
          m_irq = 1;
        end
      end
      if (bus_sel && bus_we) begin
        if (bus_addr == 0) begin m_mode = bus_wdata[1:0]; m_dis = bus_wdata[2]; end
        else if (bus_addr == 1) m_a = bus_wdata;
        else if (bus_addr == 2) m_b = bus_wdata;
        else if (bus_addr >= 8 && bus_addr <= 14) m_en[(bus_addr - 8) * 8 +: 8] = bus_wdata[7:0];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk(bus_rdata == 16'(m_rdata), "R2 read data", 64'(bus_rdata), 64'(m_rdata));
      chk(xfer_end_o == m_end, "R3/R6/R10 end pulse", 64'(xfer_end_o), 64'(m_end));
      chk(blk_end_o == m_blk, "R4/R10 block pulse", 64'(blk_end_o), 64'(m_blk));
      chk(cpu_irq_o == m_irq, "R7/R8 irq pulse", 64'(cpu_irq_o), 64'(m_irq));
      chk(act_en_o == m_en, "R9 enable bits", 64'(act_en_o), 64'(m_en));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 4'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd_expect(input int a, input int exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = 4'(a);
    @(negedge clk);
    bus_sel = 0;
    chk(bus_rdata == 16'(exp), tag, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic strobe(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      xfer_strobe = 1; xfer_src = 6'(src);
      @(negedge clk);
      xfer_strobe = 0;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1: reset state
    chk(xfer_end_o == 0 && blk_end_o == 0 && cpu_irq_o == 0, "R1 pulses low", 64'({xfer_end_o, blk_end_o, cpu_irq_o}), 64'd0);
    rd_expect(0, 0, "R1 cfg");
    rd_expect(1, 0, "R1 count A");
    rd_expect(2, 0, "R1 count B");
    rd_expect(14, 0, "R1 enable reg 6");
    // R2: map and unmapped address
    wr(8, 16'h00FF);
    wr(14, 16'h0082);
    rd_expect(14, 16'h0082, "R2 enable reg 6");
    rd_expect(15, 0, "R2 unmapped");
    // R3: normal mode
    wr(0, 0); wr(1, 3);
    strobe(2, 3);
    rd_expect(1, 0, "R3 count A after end");
    chk(act_en_o[2] == 0, "R8 served bit cleared", 64'(act_en_o[2]), 64'd0);
    chk(act_en_o[1] == 1, "R8 other bit kept", 64'(act_en_o[1]), 64'd1);
    wr(0, 3); wr(1, 1);
    strobe(5, 1);
    chk(act_en_o[5] == 0, "R3 mode 3 ends", 64'(act_en_o[5]), 64'd0);
    // R4/R5: repeat mode
    wr(0, 1); wr(1, 16'h0302);
    strobe(0, 7);
    rd_expect(1, 16'h0301, "R4 repeat reload");
    chk(act_en_o[0] == 1, "R5 repeat keeps enable", 64'(act_en_o[0]), 64'd1);
    wr(1, 0);
    strobe(0, 255);
    rd_expect(1, 16'h0001, "R4 zero means 256");
    strobe(0, 1);
    rd_expect(1, 16'h0000, "R4 reload of zero");
    // R6: block mode
    wr(0, 2); wr(1, 16'h0202); wr(2, 2);
    strobe(49, 4);
    rd_expect(2, 0, "R6 count B at end");
    chk(act_en_o[49] == 0, "R6 end clears bit", 64'(act_en_o[49]), 64'd0);
    chk(act_en_o[55] == 1, "R8 neighbour kept", 64'(act_en_o[55]), 64'd1);
    // R7: disable-interrupt flag
    wr(0, 4); wr(1, 10);
    strobe(7, 1);
    rd_expect(1, 9, "R7 count A");
    chk(act_en_o[7] == 0, "R7 flag clears bit", 64'(act_en_o[7]), 64'd0);
    // R9: bit mapping readback
    rd_expect(8, 16'h005B, "R9 enable reg 0");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule